// File: doc/BRIEF.md
# Store-Multiple Write Sequencer

This block accepts one decoded block-store request and expands it into a run of single-word memory writes. The request carries a 32-bit base address, a 16-bit register mask with one bit per register (bit i selects register i), a before/after bit, a direction bit and an update bit, all captured on a one-cycle start strobe. For every selected register, in ascending register-number order, the block offers a register index and a word address to the memory side over a valid/ready handshake, one write per accepted cycle.

The writes always climb from the lowest address to the highest, even when the request describes a downward-growing block. The starting address is therefore derived from the number of selected registers, taken as a population count of the mask when start is seen. The updated base value is computed separately. It is presented together with an update-enable flag in a one-cycle done pulse after the last write is accepted.

Control is a three-state machine. IDLE waits for start. IDLE goes to ISSUE when start arrives with a non-empty mask, and to FINISH when the mask is empty. ISSUE offers writes and stays there while writes remain. It goes to FINISH on the cycle in which the last pending write is accepted. FINISH raises done for one cycle and returns to IDLE.

Top module: `stm_seq`

## Requirements
- R1: Selected registers are written exactly once each, in ascending register number; `wr_index` carries the register number (0..15) of the mask bit being written.
- R2: Successive writes of one request go to addresses 4 bytes apart, rising; every write address has its two low bits zero, because the base's two low bits are ignored.
- R3: With `pre_index`=0 and `up_dir`=1, the first write goes to the aligned base.
- R4: With `pre_index`=1 and `up_dir`=1, the first write goes to aligned base + 4.
- R5: With `pre_index`=0 and `up_dir`=0, the first write goes to aligned base − 4·N + 4, so the highest selected register lands at the aligned base (N = number of set mask bits).
- R6: With `pre_index`=1 and `up_dir`=0, the first write goes to aligned base − 4·N, so the highest selected register lands at aligned base − 4.
- R7: With `wb_en`=1, the done cycle shows `wb_write`=1 and `wb_value` = aligned base + 4·N when `up_dir`=1, or aligned base − 4·N when `up_dir`=0.
- R8: With `wb_en`=0, the done cycle shows `wb_write`=0 and `wb_value` equal to the base exactly as given, including its low bits; `wb_write` is never high outside done.
- R9: An all-zero mask produces no write and raises done in the cycle after start is sampled.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_index` hold their values into the next cycle.
- R11: `done` is a single-cycle pulse in the cycle after the last write is accepted, never together with `wr_valid`; `busy` is high from the cycle after start through the done cycle and low after it; a start pulse seen while busy is ignored.
- R12: During reset `wr_valid`, `done`, `busy` and `wb_write` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe, sampled in IDLE only |
| base_addr | input | 32 | Base byte address of the request |
| reg_mask | input | 16 | Register select, bit i selects register i |
| pre_index | input | 1 | 1: step the address before the first store; 0: after |
| up_dir | input | 1 | 1: block grows upward from base; 0: downward |
| wb_en | input | 1 | 1: report the updated base for writeback |
| wr_valid | output | 1 | A write is offered |
| wr_ready | input | 1 | Memory side accepts the offered write |
| wr_addr | output | 32 | Word address of the offered write |
| wr_index | output | 4 | Register number of the offered write |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| wb_value | output | 32 | Updated base (or unchanged base), valid with done |
| wb_write | output | 1 | Base update requested, valid with done |

## Verification
The hardest situation to reach is a stalled write that coincides with a new start strobe, or a stall on the final pending write. Either one can expose a sequencer that reloads its mask or advances its pointer without an acceptance. The directed tasks pull `wr_ready` low on a fixed cadence, so stalls land on first, middle and last writes. One task pulses start with a different mask and base in the middle of a run and then confirms that the write stream and the writeback value match only the original request. Wrap-around below address zero and a misaligned base are both driven to check the address arithmetic at its edges.

// File: rtl/stm_seq_pkg.sv
package stm_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FINISH
    } seq_state_e;

    // Encoded as {pre_index, up_dir}
    typedef enum logic [1:0] {
        AM_DEC_AFTER  = 2'b00,
        AM_INC_AFTER  = 2'b01,
        AM_DEC_BEFORE = 2'b10,
        AM_INC_BEFORE = 2'b11
    } addr_mode_e;

endpackage

// File: rtl/stm_mask_count.sv
module stm_mask_count #(
    parameter int WIDTH = 16,
    parameter int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic [WIDTH-1:0] mask,
    output logic [CNT_W-1:0] count
);

    always_comb begin
        count = '0;
        for (int i = 0; i < WIDTH; i++) begin
            count = count + CNT_W'(mask[i]);
        end
    end

endmodule

// File: rtl/stm_low_pick.sv
module stm_low_pick #(
    parameter int WIDTH = 16,
    parameter int IDX_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] bits,
    output logic [IDX_W-1:0] idx,
    output logic [WIDTH-1:0] onehot
);

    // Lowest set bit wins: scan from the top so the lowest overwrites last.
    always_comb begin
        idx = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (bits[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign onehot = bits & (~bits + WIDTH'(1));

endmodule

// File: rtl/stm_addr_plan.sv
module stm_addr_plan
    import stm_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  addr_mode_e        mode,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] final_base
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;
    logic [ADDR_W-1:0] top_base;
    logic [ADDR_W-1:0] low_base;

    assign span     = ADDR_W'(count) * STEP;
    assign top_base = base + span;
    assign low_base = base - span;

    always_comb begin
        unique case (mode)
            AM_INC_AFTER: begin
                first_addr = base;
                final_base = top_base;
            end
            AM_INC_BEFORE: begin
                first_addr = base + STEP;
                final_base = top_base;
            end
            AM_DEC_AFTER: begin
                first_addr = low_base + STEP;
                final_base = low_base;
            end
            AM_DEC_BEFORE: begin
                first_addr = low_base;
                final_base = low_base;
            end
            default: begin
                first_addr = base;
                final_base = base;
            end
        endcase
    end

endmodule

// File: rtl/stm_seq.sv
module stm_seq
    import stm_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    parameter int IDX_W      = $clog2(NREG),
    parameter int CNT_W      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [NREG-1:0]   reg_mask,
    input  logic              pre_index,
    input  logic              up_dir,
    input  logic              wb_en,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [IDX_W-1:0]  wr_index,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] wb_value,
    output logic              wb_write
);

    localparam logic [ADDR_W-1:0] STEP       = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

    seq_state_e state_q, state_d;

    logic [NREG-1:0]   pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] wbv_q;
    logic              wbw_q;

    logic [ADDR_W-1:0] base_aligned;
    logic [CNT_W-1:0]  sel_count;
    logic [ADDR_W-1:0] plan_first;
    logic [ADDR_W-1:0] plan_final;
    logic [IDX_W-1:0]  pick_idx;
    logic [NREG-1:0]   pick_onehot;
    logic [NREG-1:0]   pend_rest;
    logic              accept;
    addr_mode_e        req_mode;

    assign base_aligned = base_addr & ALIGN_MASK;
    assign req_mode     = addr_mode_e'({pre_index, up_dir});

    stm_mask_count #(
        .WIDTH (NREG),
        .CNT_W (CNT_W)
    ) u_count (
        .mask  (reg_mask),
        .count (sel_count)
    );

    stm_addr_plan #(
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .WORD_BYTES (WORD_BYTES)
    ) u_plan (
        .base       (base_aligned),
        .count      (sel_count),
        .mode       (req_mode),
        .first_addr (plan_first),
        .final_base (plan_final)
    );

    stm_low_pick #(
        .WIDTH (NREG),
        .IDX_W (IDX_W)
    ) u_pick (
        .bits   (pend_q),
        .idx    (pick_idx),
        .onehot (pick_onehot)
    );

    assign pend_rest = pend_q & ~pick_onehot;
    assign accept    = (state_q == ST_ISSUE) && wr_ready;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (reg_mask == '0) ? ST_FINISH : ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (accept && (pend_rest == '0)) begin
                    state_d = ST_FINISH;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            addr_q <= '0;
            wbv_q  <= '0;
            wbw_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pend_q <= reg_mask;
                        addr_q <= plan_first;
                        wbv_q  <= wb_en ? plan_final : base_addr;
                        wbw_q  <= wb_en;
                    end
                end
                ST_ISSUE: begin
                    if (accept) begin
                        pend_q <= pend_rest;
                        addr_q <= addr_q + STEP;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_valid = 1'b0;
        busy     = 1'b1;
        done     = 1'b0;
        wb_write = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_ISSUE: begin
                wr_valid = 1'b1;
            end
            ST_FINISH: begin
                done     = 1'b1;
                wb_write = wbw_q;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
        wr_addr  = addr_q;
        wr_index = pick_idx;
        wb_value = wbv_q;
    end

endmodule

// File: rtl/stm_seq_chk.sv
module stm_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [IDX_W-1:0]  wr_index,
    input logic              done,
    input logic              wb_write
);

    // R10: a refused write stays on offer unchanged
    p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_index)));

    // R2: addresses rise by one word between accepted writes
    p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr == $past(wr_addr) + ADDR_W'(4))));

    // R2: every offered address is word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[1:0] == 2'b00));

    // R1: register numbers strictly ascend within a request
    p_index_ascend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_index > $past(wr_index))));

    // R11: done lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done never overlaps an offered write
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && wr_valid));

    // R8: the update flag appears only inside done
    p_wb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_write |-> done);

endmodule

bind stm_seq stm_seq_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_index (wr_index),
    .done     (done),
    .wb_write (wb_write)
);

// File: tb/stm_seq_tb.sv
module stm_seq_tb;

    logic        clk;
    logic        rst_n;
    logic        start;
    logic [31:0] base_addr;
    logic [15:0] reg_mask;
    logic        pre_index;
    logic        up_dir;
    logic        wb_en;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [3:0]  wr_index;
    logic        busy;
    logic        done;
    logic [31:0] wb_value;
    logic        wb_write;

    int n_checks = 0;
    int n_fail   = 0;

    stm_seq u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .base_addr (base_addr),
        .reg_mask  (reg_mask),
        .pre_index (pre_index),
        .up_dir    (up_dir),
        .wb_en     (wb_en),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .wr_addr   (wr_addr),
        .wr_index  (wr_index),
        .busy      (busy),
        .done      (done),
        .wb_value  (wb_value),
        .wb_write  (wb_write)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // One request: drives it, serves writes, checks every write and the done cycle.
    // stall=1 refuses every third offered cycle; inject=1 pulses start mid-run.
    task automatic run_op(input string name, input logic [31:0] base, input logic [15:0] mask,
                          input bit p, input bit u, input bit w, input bit stall, input bit inject);
        int          n = 0;
        int          k = 0;
        int          next_r = 0;
        int          cyc = 0;
        bit          finished = 0;
        bit          expect_done;
        bit          hold_pending = 0;
        logic [31:0] hold_addr = '0;
        logic [3:0]  hold_idx = '0;
        logic [31:0] ab;
        logic [31:0] first;
        logic [31:0] wb_exp;
        string       mtag;
        for (int i = 0; i < 16; i++) n += int'(mask[i]);
        ab = {base[31:2], 2'b00};
        case ({p, u})
            2'b01:   begin first = ab;                    mtag = "R3"; end
            2'b11:   begin first = ab + 32'd4;            mtag = "R4"; end
            2'b00:   begin first = ab - 32'(4 * n) + 32'd4; mtag = "R5"; end
            default: begin first = ab - 32'(4 * n);         mtag = "R6"; end
        endcase
        if (w) wb_exp = u ? ab + 32'(4 * n) : ab - 32'(4 * n);
        else   wb_exp = base;
        expect_done = (n == 0);

        @(negedge clk);
        base_addr = base; reg_mask = mask; pre_index = p; up_dir = u; wb_en = w;
        start = 1'b1; wr_ready = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R11", {name, " busy after start"}, 32'(busy), 32'd1);

        while (!finished && cyc < 200) begin
            wr_ready = 1'b0;
            if (hold_pending) begin
                chk(wr_valid === 1'b1 && wr_addr === hold_addr && wr_index === hold_idx,
                    "R10", {name, " stalled write held"}, wr_addr, hold_addr);
                hold_pending = 0;
            end
            if (done === 1'b1) begin
                chk(expect_done, (n == 0) ? "R9" : "R11", {name, " done after last write"},
                    32'(k), 32'(n));
                chk(wr_valid === 1'b0, "R11", {name, " no write with done"}, 32'(wr_valid), 32'd0);
                chk(wb_value === wb_exp, w ? "R7" : "R8", {name, " writeback value"}, wb_value, wb_exp);
                chk(wb_write === w, w ? "R7" : "R8", {name, " writeback flag"}, 32'(wb_write), 32'(w));
                finished = 1;
            end else if (expect_done) begin
                chk(1'b0, (n == 0) ? "R9" : "R11", {name, " done missing"}, 32'(done), 32'd1);
                finished = 1;
            end else if (wr_valid === 1'b1) begin
                if (!stall || (cyc % 3) != 1) begin
                    wr_ready = 1'b1;
                    while (next_r < 16 && !mask[next_r]) next_r++;
                    chk(32'(wr_index) == 32'(next_r), "R1", {name, " register order"},
                        32'(wr_index), 32'(next_r));
                    chk(wr_addr === first + 32'(4 * k), (k == 0) ? mtag : "R2",
                        {name, " write address"}, wr_addr, first + 32'(4 * k));
                    next_r++;
                    k++;
                    if (k == n) expect_done = 1;
                end else begin
                    hold_pending = 1;
                    hold_addr = wr_addr;
                    hold_idx = wr_index;
                end
            end else begin
                chk(1'b0, "R11", {name, " neither write nor done while busy"}, 32'(busy), 32'd1);
                finished = 1;
            end
            if (inject && cyc == 1) begin
                start = 1'b1; reg_mask = 16'hFFFF; base_addr = 32'h0; up_dir = ~u;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        wr_ready = 1'b0;
        start = 1'b0;
        if (!finished) chk(1'b0, "R11", {name, " request never completed"}, 32'(k), 32'(n));
        chk(busy === 1'b0 && wr_valid === 1'b0 && done === 1'b0, "R11", {name, " idle after done"},
            32'({busy, wr_valid, done}), 32'd0);
    endtask

    task automatic test_reset();
        rst_n = 1'b0; start = 1'b0; base_addr = '0; reg_mask = '0;
        pre_index = 1'b0; up_dir = 1'b0; wb_en = 1'b0; wr_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(wr_valid === 1'b0, "R12", "valid in reset", 32'(wr_valid), 32'd0);
        chk(done === 1'b0, "R12", "done in reset", 32'(done), 32'd0);
        chk(busy === 1'b0, "R12", "busy in reset", 32'(busy), 32'd0);
        chk(wb_write === 1'b0, "R12", "wb_write in reset", 32'(wb_write), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic test_modes();
        run_op("inc-after",  32'h0000_1000, 16'h000F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R3
        run_op("inc-before", 32'h0000_2000, 16'h8421, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0); // R4
        run_op("dec-after",  32'h0000_3000, 16'h000F, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0); // R5
        run_op("dec-before", 32'h0000_4000, 16'h4070, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // R6
    endtask

    task automatic test_no_update();
        run_op("no-update",     32'h0000_5000, 16'h00F0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0); // R8
        run_op("no-update-odd", 32'h0000_6003, 16'h0101, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0); // R8, R2
    endtask

    task automatic test_edges();
        run_op("empty-mask",   32'h0000_7000, 16'h0000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R9
        run_op("full-mask",    32'h0000_0100, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // R1, R6
        run_op("misaligned",   32'h0000_6003, 16'h0006, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0); // R2, R3
        run_op("single-top",   32'h0000_8000, 16'h8000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0); // R4
        run_op("wrap-low",     32'h0000_0004, 16'h0003, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0); // R6
        run_op("dec-after-st", 32'h0000_9000, 16'h1248, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0); // R5, R10
    endtask

    task automatic test_start_ignored();
        run_op("start-while-busy", 32'h0000_A000, 16'h00F3, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // R11
    endtask

    initial begin
        test_reset();
        test_modes();
        test_no_update();
        test_edges();
        test_start_ignored();
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual run still active, expected completion");
        summary();
        $finish;
    end

endmodule